// File: doc/BRIEF.md
# Eight-Channel DMA Bus Arbiter with Selectable Priority

This block decides which of eight DMA channels owns a single shared bus. Each channel raises a request line. The arbiter then issues a one-hot grant together with the binary index of the winner. The owner keeps the grant for a whole block or burst, until it pulses its done line. After that, the bus is free and the pending requests are evaluated again.

A mode input selects how the winner is chosen. In static mode the lowest-numbered requester wins. In rotating mode the search begins one position past the channel that most recently finished, and wraps from channel 7 back to channel 0. The mode is read only while the bus is free, so changing it never disturbs a transfer in progress. A request may come from software or from a peripheral interrupt, and several channels may share one source. The arbiter sees only the resulting request lines.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, `gnt` is all zeros, `gnt_idx` is 0 and the rotating search start is channel 0.
- R2: `gnt` has at most one bit set. Whenever a bit is set, `gnt_idx` holds that bit's position (bit i of `gnt` corresponds to channel i).
- R3: While no grant is active and at least one request is high at a rising edge, a grant to one of the requesting channels is visible after that edge.
- R4: When `rr_mode` is 0 at the arbitration edge, the requesting channel with the lowest index receives the grant.
- R5: When `rr_mode` is 1 at the arbitration edge, the first requesting channel at or above the search start receives the grant, wrapping from 7 to 0. Every completion moves the search start to the finished channel's index plus one, modulo 8.
- R6: An active grant stays unchanged until the granted channel's done bit is high at a rising edge. This holds even if other requests appear or the granted channel's own request drops.
- R7: A done bit from any channel that does not hold the grant has no effect.
- R8: A done bit from the granted channel at a rising edge clears `gnt` after that edge. The next grant follows no earlier than the edge after that.
- R9: A change of `rr_mode` during an active grant leaves that grant intact. The new mode governs only the next arbitration.
- R10: With no request pending and no grant active, `gnt` stays all zeros and the search start does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 0 selects static priority, 1 selects rotating priority |
| req | input | 8 | Per-channel bus request |
| done | input | 8 | Per-channel end-of-block pulse |
| gnt | output | 8 | One-hot grant |
| gnt_idx | output | 3 | Index of the granted channel |

## Verification
On every cycle, the assertions check that the grant is one-hot and consistent with its index. They also check that a grant is held until the owner's done bit and cleared right after it, that a free bus with pending requests is taken on the next edge, that a new grant always goes to a channel that was requesting, and that static mode picks the lowest requester. The rotating search start is internal and is not visible at the ports, so only the bench scenarios can show that it advances past the finished channel, wraps at channel 7, and stays put through idle cycles. The same holds for a mode change made in the middle of a grant, which shows its effect only at the following arbitration.

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int N = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rr_mode,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  done,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);

  logic          busy;
  logic [IW-1:0] ptr;
  logic [IW-1:0] fix_idx, rr_idx, pick_idx;
  logic          any_req;

  assign any_req = |req;

  always_comb begin
    fix_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) fix_idx = IW'(i);
  end

  always_comb begin
    logic hit;
    hit = 1'b0;
    rr_idx = ptr;
    for (int i = 0; i < N; i++) begin
      int k;
      k = (int'(ptr) + i) % N;
      if (!hit && req[k]) begin
        hit = 1'b1;
        rr_idx = IW'(k);
      end
    end
  end

  assign pick_idx = rr_mode ? rr_idx : fix_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      gnt     <= '0;
      gnt_idx <= '0;
      ptr     <= '0;
    end else if (busy) begin
      if (done[gnt_idx]) begin
        busy <= 1'b0;
        gnt  <= '0;
        ptr  <= IW'((int'(gnt_idx) + 1) % N);
      end
    end else if (any_req) begin
      busy    <= 1'b1;
      gnt_idx <= pick_idx;
      gnt     <= N'(1) << pick_idx;
    end
  end

endmodule

module dma_chan_arbiter_chk #(
  parameter int N = 8,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rr_mode,
  input logic [N-1:0]  req,
  input logic [N-1:0]  done,
  input logic [N-1:0]  gnt,
  input logic [IW-1:0] gnt_idx
);

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  index_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> gnt[gnt_idx]);

  // R3
  free_bus_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req != '0) |=> (gnt != '0));

  // R3
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && $past(gnt) == '0) |-> (($past(req) & gnt) != '0));

  // R4
  static_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && $past(gnt) == '0 && !$past(rr_mode))
      |-> (gnt == ($past(req) & (~$past(req) + N'(1)))));

  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !done[gnt_idx]) |=> (gnt == $past(gnt)));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && done[gnt_idx]) |=> (gnt == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req == '0) |=> (gnt == '0));

endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .req(req),
  .done(done), .gnt(gnt), .gnt_idx(gnt_idx)
);

// File: tb/dma_chan_arbiter_tb.sv
module dma_chan_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rr_mode = 1'b0;
  logic [7:0] req = '0;
  logic [7:0] done = '0;
  logic [7:0] gnt;
  logic [2:0] gnt_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_chan_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .req(req),
    .done(done), .gnt(gnt), .gnt_idx(gnt_idx)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    req = '0; done = '0; rr_mode = 1'b0;
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic finish_grant();
    done = gnt;
    cyc(1);
    done = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 gnt after reset", gnt, 8'h00);
    chk("R1 idx after reset", {5'b0, gnt_idx}, 8'd0);
  endtask

  task automatic t_fixed();
    do_reset();
    req = 8'b1010_0100;
    cyc(1);
    chk("R3/R4 lowest requester", gnt, 8'b0000_0100);
    chk("R2 index of grant", {5'b0, gnt_idx}, 8'd2);
    req = 8'b1010_0001;
    cyc(2);
    chk("R6 held despite higher request and own drop", gnt, 8'b0000_0100);
    done = 8'b0010_0001;
    cyc(1);
    done = '0;
    chk("R7 foreign done ignored", gnt, 8'b0000_0100);
    finish_grant();
    chk("R8 cleared after own done", gnt, 8'h00);
    cyc(1);
    chk("R4 next grant lowest", gnt, 8'b0000_0001);
    req = '0;
    finish_grant();
  endtask

  task automatic t_rr();
    do_reset();
    rr_mode = 1'b1;
    req = 8'b1000_0001;
    cyc(1);
    chk("R5 start at channel 0", gnt, 8'b0000_0001);
    finish_grant();
    cyc(1);
    chk("R5 search past finished channel", gnt, 8'b1000_0000);
    finish_grant();
    cyc(1);
    chk("R5 wrap from 7 to 0", gnt, 8'b0000_0001);
    req = '0;
    finish_grant();
  endtask

  task automatic t_mode();
    do_reset();
    rr_mode = 1'b0;
    req = 8'b0010_0100;
    cyc(1);
    chk("R4 static grant", gnt, 8'b0000_0100);
    rr_mode = 1'b1;
    req = 8'b0010_0001;
    cyc(2);
    chk("R9 mode change keeps grant", gnt, 8'b0000_0100);
    finish_grant();
    cyc(1);
    chk("R9 rotating used at next arbitration", gnt, 8'b0010_0000);
    chk("R2 index after switch", {5'b0, gnt_idx}, 8'd5);
    req = '0;
    finish_grant();
  endtask

  task automatic t_idle();
    do_reset();
    rr_mode = 1'b1;
    req = 8'b0000_1000;
    cyc(1);
    finish_grant();
    req = '0;
    cyc(4);
    chk("R10 no grant while idle", gnt, 8'h00);
    req = 8'b0001_0100;
    cyc(1);
    chk("R10 start unchanged through idle", gnt, 8'b0001_0000);
    req = '0;
    finish_grant();
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_rr();
    t_mode();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule